// File: doc/BRIEF.md
# Six-Pin GPIO Interrupt and Status LED Multiplexer

This block owns six general-purpose pins. Each pin runs in one of two roles. In GPIO role the pin is an input. Its level passes through a two-flop synchronizer and is compared against a polarity bit for that pin. A match latches a sticky interrupt status bit. In LED role the pin is always driven. It shows one indication from one of three Ethernet ports, chosen by a 2-bit function code that remaps all six pins at once.

The LED role and the function code take their reset values from strap inputs. A one-cycle configuration strobe can change them later. LED outputs are active-low: a lit indication drives 0. Each LED pin can be set to open-drain. Activity indications are stretched by a programmable counter, so that a short burst of traffic stays visible.

Top module: `gpio_led_mux`

## Requirements
- R1: While reset is asserted, LED role takes the value of `strap_led_en`, `int_sts` and `irq` are 0, and every LED-role pin drives 1 (dark).
- R2: In GPIO role, pin i sets `int_sts[i]` when its synchronized level equals `irq_pol[i]`: high when the bit is 1, low when it is 0. A level held on `pin_in` is visible in `int_sts` at the third rising edge after it is applied.
- R3: A pin in LED role never sets its interrupt status bit, whatever its level or polarity.
- R4: Status bits are sticky. A 1 in `int_clr[i]` for one cycle clears bit i at the next edge. If the triggering level is still present, the bit sets again one edge later.
- R5: `irq` is 1 exactly when some bit is set in both `int_sts` and `irq_en`.
- R6: In LED role `pin_oe[i]` is 1 and `pin_od[i]` follows `led_od[i]`. In GPIO role `pin_oe`, `pin_od` and `pin_out` are 0.
- R7: Function code 0 maps pins 5..0 to: port 2 duplex/collision, port 2 link/activity, port 2 speed, port 1 duplex/collision, port 1 link/activity, port 1 speed.
- R8: Function code 1 maps pins 5..0 to: port 2 duplex/collision, port 2 100M link/activity, port 2 10M link/activity, port 1 duplex/collision, port 1 100M link/activity, port 1 10M link/activity.
- R9: Function code 2 maps pins 5..0 to: port 0 link/activity, port 2 link/activity, port 2 speed, port 0 speed, port 1 link/activity, port 1 speed.
- R10: Function code 3 maps pins 5..0 to: port 0 RX valid, port 2 RX valid, port 2 TX enable, port 0 TX enable, port 1 RX valid, port 1 TX enable.
- R11: The indications are defined as follows. Link/activity is lit when link is up and stretched activity is low. Speed is link AND 100M. Duplex/collision is full-duplex OR collision. 100M link/activity is link/activity AND 100M. 10M link/activity is link/activity AND NOT 100M. RX valid and TX enable follow their inputs. An LED pin drives the inverse of its indication, registered one edge after the inputs are sampled.
- R12: Activity at a port is stretched: after the last edge that samples activity high, the port counts as active for `stretch_len` further edges.
- R13: A high `cfg_we` at an edge loads `cfg_led_en` and `cfg_led_fun` as the new LED role and function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_led_en | input | 6 | Reset value of LED role per pin |
| strap_led_fun | input | 2 | Reset value of the function code |
| cfg_we | input | 1 | Load strobe for LED role and function code |
| cfg_led_en | input | 6 | New LED role per pin |
| cfg_led_fun | input | 2 | New function code |
| led_od | input | 6 | Open-drain select per LED pin |
| irq_pol | input | 6 | Interrupt level per pin (1 = high) |
| irq_en | input | 6 | Interrupt enable per pin |
| int_clr | input | 6 | Write-1 clear of status bits |
| stretch_len | input | CNT_W | Activity stretch length in cycles |
| pin_in | input | 6 | Pin input levels |
| p_link | input | 3 | Link up per port |
| p_act | input | 3 | Activity per port |
| p_spd100 | input | 3 | 100M speed per port |
| p_fdx | input | 3 | Full duplex per port |
| p_col | input | 3 | Collision per port |
| p_rxdv | input | 3 | RX data valid per port |
| p_txen | input | 3 | TX enable per port |
| pin_out | output | 6 | Pin output value |
| pin_oe | output | 6 | Pin output enable |
| pin_od | output | 6 | Pin open-drain select |
| int_sts | output | 6 | Sticky interrupt status |
| irq | output | 1 | Combined interrupt |

## Verification
Random port status vectors are applied under all four function codes with stretching off. This separates each pin's mapping and each indication formula from its neighbours. Random pin levels, polarities and LED roles are checked after a clear, and then again after a second pattern without a clear. The first step shows polarity and LED masking. The second shows that status bits are sticky rather than following the level. Directed cases cover all-high and all-low pins under both polarities, the clear-then-reset timing, a one-cycle activity pulse under a three-cycle stretch, and a reload of the role and function code.

// File: rtl/gpio_led_mux.sv
module gpio_led_mux #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       strap_led_en,
  input  logic [1:0]       strap_led_fun,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_led_en,
  input  logic [1:0]       cfg_led_fun,
  input  logic [5:0]       led_od,
  input  logic [5:0]       irq_pol,
  input  logic [5:0]       irq_en,
  input  logic [5:0]       int_clr,
  input  logic [CNT_W-1:0] stretch_len,
  input  logic [5:0]       pin_in,
  input  logic [2:0]       p_link,
  input  logic [2:0]       p_act,
  input  logic [2:0]       p_spd100,
  input  logic [2:0]       p_fdx,
  input  logic [2:0]       p_col,
  input  logic [2:0]       p_rxdv,
  input  logic [2:0]       p_txen,
  output logic [5:0]       pin_out,
  output logic [5:0]       pin_oe,
  output logic [5:0]       pin_od,
  output logic [5:0]       int_sts,
  output logic             irq
);

  localparam int NPIN  = 6;
  localparam int NPORT = 3;

  logic [NPIN-1:0]  led_en_q, s1, s2, hit, led_q, lit;
  logic [1:0]       fun_q;
  logic [NPORT-1:0] act_s, la, spd, fdc, la100, la10;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      led_en_q <= strap_led_en;
      fun_q    <= strap_led_fun;
    end else if (cfg_we) begin
      led_en_q <= cfg_led_en;
      fun_q    <= cfg_led_fun;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end

  assign hit = ~(s2 ^ irq_pol) & ~led_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) int_sts <= '0;
    else        int_sts <= ~int_clr & (int_sts | hit);

  assign irq = |(int_sts & irq_en);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (p_act[p])   cnt <= stretch_len;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    assign act_s[p] = p_act[p] | (cnt != '0);
  end

  assign la    = p_link & ~act_s;
  assign spd   = p_link & p_spd100;
  assign fdc   = p_fdx | p_col;
  assign la100 = la & p_spd100;
  assign la10  = la & ~p_spd100;

  always_comb
    case (fun_q)
      2'd0:    lit = {fdc[2], la[2], spd[2], fdc[1], la[1], spd[1]};
      2'd1:    lit = {fdc[2], la100[2], la10[2], fdc[1], la100[1], la10[1]};
      2'd2:    lit = {la[0], la[2], spd[2], spd[0], la[1], spd[1]};
      default: lit = {p_rxdv[0], p_rxdv[2], p_txen[2], p_txen[0], p_rxdv[1], p_txen[1]};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) led_q <= '1;
    else        led_q <= ~lit;

  assign pin_out = led_q & led_en_q;
  assign pin_oe  = led_en_q;
  assign pin_od  = led_en_q & led_od;

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    // R3
    led_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(led_en_q[i] && !int_sts[i]) |-> !int_sts[i]);
    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(int_clr[i]) |-> !int_sts[i]);
    // R4
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(int_sts[i] && !int_clr[i]) |-> int_sts[i]);
    // R2
    pol_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_sts[i]) |-> $past(s2[i] == irq_pol[i]));
  end

  // R6
  od_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_od & ~pin_oe) == '0);

endmodule

// File: tb/gpio_led_mux_tb.sv
`timescale 1ns/1ps
module gpio_led_mux_tb;
  logic clk = 0, rst_n = 0;
  logic [5:0] strap_led_en = 6'b101010, cfg_led_en = 0, led_od = 0, irq_pol = 0, irq_en = 0, int_clr = 0, pin_in = 0;
  logic [1:0] strap_led_fun = 2'd2, cfg_led_fun = 0;
  logic cfg_we = 0;
  logic [7:0] stretch_len = 0;
  logic [2:0] p_link = 0, p_act = 0, p_spd100 = 0, p_fdx = 0, p_col = 0, p_rxdv = 0, p_txen = 0;
  logic [5:0] pin_out, pin_oe, pin_od, int_sts;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_led_mux #(.CNT_W(8)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_lit(input logic [1:0] f);
    logic [2:0] la, sp, fc, l1, l0;
    la = p_link & ~p_act; sp = p_link & p_spd100; fc = p_fdx | p_col;
    l1 = la & p_spd100; l0 = la & ~p_spd100;
    case (f)
      2'd0: return {fc[2], la[2], sp[2], fc[1], la[1], sp[1]};
      2'd1: return {fc[2], l1[2], l0[2], fc[1], l1[1], l0[1]};
      2'd2: return {la[0], la[2], sp[2], sp[0], la[1], sp[1]};
      default: return {p_rxdv[0], p_rxdv[2], p_txen[2], p_txen[0], p_rxdv[1], p_txen[1]};
    endcase
  endfunction

  task automatic load_cfg(input logic [5:0] en, input logic [1:0] f);
    @(negedge clk); cfg_led_en = en; cfg_led_fun = f; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); int_clr = '1;
    @(negedge clk); int_clr = '0;
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] en, exp, prev;
    logic [1:0] f;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pin_oe == 6'b101010, "R1", {2'b0, pin_oe}, 8'h2a);
    chk(pin_out == 6'b101010, "R1", {2'b0, pin_out}, 8'h2a);
    chk(int_sts == 0 && irq == 0, "R1", {2'b0, int_sts}, 0);
    irq_pol = '1;
    rst_n = 1;
    @(negedge clk);

    // R13 reload
    load_cfg(6'b010101, 2'd3);
    chk(pin_oe == 6'b010101, "R13", {2'b0, pin_oe}, 8'h15);
    // R6 od / gpio role
    led_od = 6'b111100;
    @(negedge clk);
    chk(pin_od == 6'b010100, "R6", {2'b0, pin_od}, 8'h14);
    chk((pin_out & ~pin_oe) == 0, "R6", {2'b0, pin_out}, 0);

    // R7 R8 R9 R10 R11 mapping, random status
    for (int n = 0; n < 200; n++) begin
      f = n[1:0];
      load_cfg('1, f);
      {p_link, p_act, p_spd100, p_fdx, p_col, p_rxdv, p_txen} = 21'($urandom);
      @(negedge clk); @(negedge clk);
      exp = ~ref_lit(f);
      case (f)
        2'd0: chk(pin_out == exp, "R7 R11", {2'b0, pin_out}, {2'b0, exp});
        2'd1: chk(pin_out == exp, "R8 R11", {2'b0, pin_out}, {2'b0, exp});
        2'd2: chk(pin_out == exp, "R9 R11", {2'b0, pin_out}, {2'b0, exp});
        default: chk(pin_out == exp, "R10 R11", {2'b0, pin_out}, {2'b0, exp});
      endcase
    end

    // R12 stretch
    load_cfg('1, 2'd0);
    {p_link, p_act, p_spd100, p_fdx, p_col, p_rxdv, p_txen} = '0;
    p_link = 3'b010; stretch_len = 3;
    @(negedge clk); @(negedge clk);
    chk(pin_out[1] == 0, "R12", {7'b0, pin_out[1]}, 0);
    p_act = 3'b010;
    @(negedge clk); p_act = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(pin_out[1] == 1, "R12", {7'b0, pin_out[1]}, 1);
    end
    @(negedge clk);
    chk(pin_out[1] == 0, "R12", {7'b0, pin_out[1]}, 0);
    stretch_len = 0;

    // R2 directed both polarities on every pin
    load_cfg('0, 2'd0);
    for (int p = 0; p < 2; p++) begin
      irq_pol = p[0] ? 6'h3f : 6'h00;
      pin_in = p[0] ? 6'h00 : 6'h3f;
      repeat (3) @(negedge clk);
      clear_all();
      @(negedge clk);
      chk(int_sts == 0, "R2", {2'b0, int_sts}, 0);
      pin_in = ~pin_in;
      @(negedge clk); @(negedge clk);
      chk(int_sts == 0, "R2", {2'b0, int_sts}, 0);
      @(negedge clk);
      chk(int_sts == 6'h3f, "R2", {2'b0, int_sts}, 8'h3f);
    end

    // R4 clear then re-set while level held
    irq_en = '1;
    clear_all();
    chk(int_sts == 0, "R4", {2'b0, int_sts}, 0);
    @(negedge clk);
    chk(int_sts == 6'h3f, "R4", {2'b0, int_sts}, 8'h3f);

    // R2 R3 R4 R5 random
    for (int n = 0; n < 100; n++) begin
      en = 6'($urandom);
      load_cfg(en, 2'd0);
      irq_pol = 6'($urandom); irq_en = 6'($urandom); pin_in = 6'($urandom);
      repeat (3) @(negedge clk);
      clear_all();
      @(negedge clk);
      exp = ~(pin_in ^ irq_pol) & ~en;
      chk(int_sts == exp, "R2 R3", {2'b0, int_sts}, {2'b0, exp});
      chk(irq == |(exp & irq_en), "R5", {7'b0, irq}, {7'b0, |(exp & irq_en)});
      prev = exp;
      pin_in = 6'($urandom);
      repeat (4) @(negedge clk);
      exp = prev | (~(pin_in ^ irq_pol) & ~en);
      chk(int_sts == exp, "R4 R3", {2'b0, int_sts}, {2'b0, exp});
      chk(irq == |(exp & irq_en), "R5", {7'b0, irq}, {7'b0, |(exp & irq_en)});
      chk((pin_oe == en) && ((pin_out & ~en) == 0), "R6", {2'b0, pin_oe}, {2'b0, en});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule